// File: doc/BRIEF.md
# Interlaced Blanking Timing Generator

This block derives the horizontal and vertical blanking events of an interlaced video raster from one system clock. A horizontal timer splits every scanline into a render half and a blank half of equal length. A vertical timer splits every frame into a vertical render half and a vertical sync half of equal length. A field bit flips at the end of each vertical sync interval and marks odd and even frames.

Every transition is reported twice: once as a level (`hblank_o`, `vsync_o`) and once as a one-cycle pulse on entering and on leaving that phase. Counter gating logic and interrupt controllers elsewhere in the chip consume these signals. One input picks between two sets of period parameters, the 50 Hz set and the 59.94 Hz set. Any change on that input restarts both timers. Since both timers run from the same clock, a horizontal and a vertical event can land on the same cycle. A small debug code then says which event class is reported first.

Top module: `blank_timing_gen`

## Requirements
- R1: While reset is held, all level outputs, all pulse outputs, `field_o` and `evt_first_o` are 0, and the 59.94 Hz parameter set (select value 0) is active.
- R2: `hblank_o` toggles after each run of H_HALF clock cycles. `hblank_start_o` is high for exactly the cycle in which `hblank_o` first reads 1, and `hblank_end_o` is high for exactly the cycle in which it first reads 0 again.
- R3: H_HALF is H_HALF_NTSC while the active select is 0 and H_HALF_PAL while it is 1, so consecutive `hblank_start_o` pulses are 2*H_HALF cycles apart.
- R4: `vsync_o` toggles after each run of V_HALF cycles (V_HALF_NTSC for select 0, V_HALF_PAL for select 1). `vsync_start_o` and `vsync_end_o` mark its rising and falling cycles in the same way as R2.
- R5: `field_o` inverts in exactly the cycle in which `vsync_end_o` is high, and in no other cycle except a restart.
- R6: When `pal_sel_i` differs from the active select at a clock edge, that edge loads the new select and restarts both timers. Both timers go to their render phase with zero elapsed time, `field_o` is cleared, and no pulse is emitted. The first `hblank_start_o` then comes H_HALF edges after the restart edge.
- R7: Phase changes do not drift. Counted from the first `hblank_start_o`, the k-th following one comes exactly k*2*H_HALF cycles later.
- R8: A horizontal and a vertical event that fall on the same cycle are both asserted in that cycle. `evt_first_o` is 2'b01 when any horizontal pulse is high, 2'b10 when only a vertical pulse is high, and 2'b00 otherwise.
- R9: Deassertion of `rst_n` passes through a two-stage synchronizer. The first `hblank_start_o` after release comes 2 + H_HALF rising edges after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pal_sel_i | input | 1 | Parameter set select: 0 = 59.94 Hz set, 1 = 50 Hz set |
| hblank_o | output | 1 | High during the horizontal blank half |
| hblank_start_o | output | 1 | One-cycle pulse on entering horizontal blank |
| hblank_end_o | output | 1 | One-cycle pulse on leaving horizontal blank |
| vsync_o | output | 1 | High during the vertical sync half |
| vsync_start_o | output | 1 | One-cycle pulse on entering vertical sync |
| vsync_end_o | output | 1 | One-cycle pulse on leaving vertical sync |
| field_o | output | 1 | Field parity, flips at each vertical sync end |
| evt_first_o | output | 2 | Debug code for the first event class this cycle |

## Verification
A horizontal pulse and a vertical pulse can be asserted in the same cycle. This happens whenever the vertical half period is a multiple of the horizontal one, or when the elapsed time is a common multiple of both. The bench picks a vertical half of 42 cycles against a horizontal half of 5. Most vertical events then fall on their own cycle, and every 210 cycles one falls together with a horizontal event. In the 50 Hz set, 56 against 7, every vertical event coincides with a horizontal one. A behavioural model compares all pulses and `evt_first_o` with the design on every cycle. The bench also counts the coincident cycles and the vertical-only cycles, so both orderings of the debug code are known to have occurred.

// File: rtl/btg_pkg.sv
package btg_pkg;

  typedef enum logic {
    PH_RENDER = 1'b0,
    PH_BLANK  = 1'b1
  } phase_e;

  typedef enum logic [1:0] {
    EVF_NONE = 2'b00,
    EVF_HORZ = 2'b01,
    EVF_VERT = 2'b10
  } evt_first_e;

  typedef struct packed {
    logic enter;
    logic leave;
  } edge_t;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/btg_phase_timer.sv
module btg_phase_timer
  import btg_pkg::*;
#(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             restart_i,
  input  logic [LEN_W-1:0] half_len_i,
  output phase_e           phase_o,
  output edge_t            edge_o
);

  logic [LEN_W-1:0] cnt_q, cnt_d;
  phase_e           ph_q, ph_d;
  edge_t            edg_q, edg_d;
  logic             wrap;

  assign wrap = (cnt_q == (half_len_i - LEN_W'(1)));

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    edg_d = '0;
    if (restart_i) begin
      cnt_d = '0;
      ph_d  = PH_RENDER;
    end else if (wrap) begin
      cnt_d       = '0;
      ph_d        = (ph_q == PH_RENDER) ? PH_BLANK : PH_RENDER;
      edg_d.enter = (ph_q == PH_RENDER);
      edg_d.leave = (ph_q == PH_BLANK);
    end else begin
      cnt_d = cnt_q + LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= PH_RENDER;
      edg_q <= '0;
    end else if (clk_en) begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
      edg_q <= edg_d;
    end
  end

  assign phase_o = ph_q;
  assign edge_o  = edg_q;

endmodule

// File: rtl/btg_field_reg.sv
module btg_field_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_en,
  input  logic restart_i,
  input  logic flip_i,
  output logic field_o
);

  logic fld_q, fld_d;

  always_comb begin
    fld_d = fld_q;
    if (restart_i)   fld_d = 1'b0;
    else if (flip_i) fld_d = ~fld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fld_q <= 1'b0;
    else if (clk_en) fld_q <= fld_d;
  end

  assign field_o = fld_q;

endmodule

// File: rtl/btg_std_ctrl.sv
module btg_std_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_en,
  input  logic sel_i,
  output logic std_o,
  output logic restart_o
);

  logic std_q, std_d;

  assign restart_o = (sel_i != std_q);

  always_comb begin
    std_d = std_q;
    if (restart_o) std_d = sel_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      std_q <= 1'b0;
    else if (clk_en) std_q <= std_d;
  end

  assign std_o = std_q;

endmodule

// File: rtl/blank_timing_gen.sv
module blank_timing_gen
  import btg_pkg::*;
#(
  parameter int unsigned H_HALF_NTSC = 9371,
  parameter int unsigned H_HALF_PAL  = 9437,
  parameter int unsigned V_HALF_NTSC = 2460060,
  parameter int unsigned V_HALF_PAL  = 2949120,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pal_sel_i,
  output logic       hblank_o,
  output logic       hblank_start_o,
  output logic       hblank_end_o,
  output logic       vsync_o,
  output logic       vsync_start_o,
  output logic       vsync_end_o,
  output logic       field_o,
  output logic [1:0] evt_first_o
);

  localparam int unsigned H_MAX = max_u(H_HALF_NTSC, H_HALF_PAL);
  localparam int unsigned V_MAX = max_u(V_HALF_NTSC, V_HALF_PAL);
  localparam int unsigned HW    = $clog2(H_MAX + 1);
  localparam int unsigned VW    = $clog2(V_MAX + 1);

  // reset release synchronizer
  logic [SYNC_STAGES-1:0] rs_q;
  logic                   core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign core_rst_n = rs_q[SYNC_STAGES-1];

  logic clk_en;
  assign clk_en = 1'b1;

  logic std_q, restart;

  btg_std_ctrl u_std (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .clk_en    (clk_en),
    .sel_i     (pal_sel_i),
    .std_o     (std_q),
    .restart_o (restart)
  );

  logic [HW-1:0] h_len;
  logic [VW-1:0] v_len;
  assign h_len = std_q ? HW'(H_HALF_PAL) : HW'(H_HALF_NTSC);
  assign v_len = std_q ? VW'(V_HALF_PAL) : VW'(V_HALF_NTSC);

  phase_e h_ph, v_ph;
  edge_t  h_edge, v_edge;

  btg_phase_timer #(.LEN_W(HW)) u_htmr (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .clk_en     (clk_en),
    .restart_i  (restart),
    .half_len_i (h_len),
    .phase_o    (h_ph),
    .edge_o     (h_edge)
  );

  btg_phase_timer #(.LEN_W(VW)) u_vtmr (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .clk_en     (clk_en),
    .restart_i  (restart),
    .half_len_i (v_len),
    .phase_o    (v_ph),
    .edge_o     (v_edge)
  );

  // the field flips on the same edge that registers the vsync end pulse
  logic v_leave_next;
  assign v_leave_next = !restart && (v_ph == PH_BLANK) &&
                        (u_vtmr.cnt_q == (v_len - VW'(1)));

  btg_field_reg u_fld (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .clk_en    (clk_en),
    .restart_i (restart),
    .flip_i    (v_leave_next),
    .field_o   (field_o)
  );

  evt_first_e first;
  always_comb begin
    if (h_edge.enter || h_edge.leave)      first = EVF_HORZ;
    else if (v_edge.enter || v_edge.leave) first = EVF_VERT;
    else                                   first = EVF_NONE;
  end

  assign hblank_o       = (h_ph == PH_BLANK);
  assign hblank_start_o = h_edge.enter;
  assign hblank_end_o   = h_edge.leave;
  assign vsync_o        = (v_ph == PH_BLANK);
  assign vsync_start_o  = v_edge.enter;
  assign vsync_end_o    = v_edge.leave;
  assign evt_first_o    = first;

endmodule

// File: rtl/btg_checker.sv
module btg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       hblank_o,
  input logic       hblank_start_o,
  input logic       hblank_end_o,
  input logic       vsync_o,
  input logic       vsync_start_o,
  input logic       vsync_end_o,
  input logic       field_o,
  input logic [1:0] evt_first_o
);

  AST_H_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(hblank_start_o && hblank_end_o)); // R2
  AST_H_RISE_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hblank_o) |-> hblank_start_o); // R2
  AST_H_START_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    hblank_start_o |-> hblank_o); // R2
  AST_V_RISE_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync_o) |-> vsync_start_o); // R4
  AST_V_END_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_end_o |-> !vsync_o); // R4
  AST_FIELD_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_end_o |-> (field_o != $past(field_o))); // R5
  AST_FIELD_RISE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(field_o) |-> vsync_end_o); // R5
  AST_EVT_HORZ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hblank_start_o && vsync_start_o) |-> (evt_first_o == 2'b01)); // R8

endmodule

bind blank_timing_gen btg_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .hblank_o       (hblank_o),
  .hblank_start_o (hblank_start_o),
  .hblank_end_o   (hblank_end_o),
  .vsync_o        (vsync_o),
  .vsync_start_o  (vsync_start_o),
  .vsync_end_o    (vsync_end_o),
  .field_o        (field_o),
  .evt_first_o    (evt_first_o)
);

// File: tb/tb_blank_timing_gen.sv
module tb_blank_timing_gen;

  localparam int HN = 5;
  localparam int HP = 7;
  localparam int VN = 42;
  localparam int VP = 56;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pal_sel = 1'b0;
  logic       hblank, hs, he, vsync, vs, ve, field;
  logic [1:0] evt;

  always #5 clk = ~clk;

  blank_timing_gen #(
    .H_HALF_NTSC(HN), .H_HALF_PAL(HP), .V_HALF_NTSC(VN), .V_HALF_PAL(VP)
  ) dut (
    .clk(clk), .rst_n(rst_n), .pal_sel_i(pal_sel),
    .hblank_o(hblank), .hblank_start_o(hs), .hblank_end_o(he),
    .vsync_o(vsync), .vsync_start_o(vs), .vsync_end_o(ve),
    .field_o(field), .evt_first_o(evt)
  );

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference
  int m_hc, m_vc;
  bit m_hph, m_vph, m_fld, m_hs, m_he, m_vs, m_ve, m_std, m_r1, m_r2;

  task automatic m_clear(input bit std);
    m_hc = 0; m_vc = 0; m_hph = 0; m_vph = 0; m_fld = 0;
    m_hs = 0; m_he = 0; m_vs = 0; m_ve = 0; m_std = std;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_clear(1'b0);
      m_r1 = 0; m_r2 = 0;
    end else begin
      if (!m_r2) m_clear(1'b0);
      else if (pal_sel != m_std) m_clear(pal_sel);
      else begin
        int hl, vl;
        hl = m_std ? HP : HN;
        vl = m_std ? VP : VN;
        m_hs = 0; m_he = 0; m_vs = 0; m_ve = 0;
        if (m_hc == hl - 1) begin
          m_hc = 0; m_hph = !m_hph; m_hs = m_hph; m_he = !m_hph;
        end else m_hc++;
        if (m_vc == vl - 1) begin
          m_vc = 0; m_vph = !m_vph; m_vs = m_vph; m_ve = !m_vph;
          if (m_ve) m_fld = !m_fld;
        end else m_vc++;
      end
      m_r2 = m_r1; m_r1 = 1;
    end
  end

  int cyc = 0;
  int hs_t[$];
  int ncoinc = 0;
  int nvonly = 0;

  task automatic step();
    int e_evt;
    @(negedge clk);
    cyc++;
    e_evt = (m_hs || m_he) ? 1 : ((m_vs || m_ve) ? 2 : 0);
    chk("R2 hblank/start/end", {hblank, hs, he}, {m_hph, m_hs, m_he});
    chk("R4 vsync/start/end", {vsync, vs, ve}, {m_vph, m_vs, m_ve});
    chk("R5 field", field, m_fld);
    chk("R8 evt_first", evt, e_evt);
    if (hs) hs_t.push_back(cyc);
    if ((hs || he) && (vs || ve)) ncoinc++;
    if (!(hs || he) && (vs || ve)) nvonly++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {hblank, hs, he, vsync, vs, ve, field, evt}, 0);
    rst_n = 1'b1;
    cyc = 0;
    repeat (400) step();
    chk("R9 first hblank start after release", hs_t[0], 2 + HN);
    chk("R7 tenth hblank start no drift", hs_t[9] - hs_t[0], 9 * 2 * HN);
    chk("R3 ntsc line period", hs_t[1] - hs_t[0], 2 * HN);
    chk("R8 coincident events seen", int'(ncoinc > 0), 1);
    chk("R8 vertical-only events seen", int'(nvonly > 0), 1);
    for (int i = 0; i < 2000 && !(field && hblank && vsync); i++) step();
    chk("R6 precondition field/hblank high", {field, hblank}, 3);
    pal_sel = 1'b1;
    cyc = 0;
    hs_t.delete();
    ncoinc = 0;
    step();
    chk("R6 restart clears phases and field", {hblank, vsync, field, hs, he, vs, ve}, 0);
    repeat (300) step();
    chk("R6 first hblank start after restart", hs_t[0], 1 + HP);
    chk("R3 pal line period", hs_t[1] - hs_t[0], 2 * HP);
    chk("R7 pal no drift", hs_t[5] - hs_t[0], 5 * 2 * HP);
    chk("R8 pal coincidence seen", int'(ncoinc > 0), 1);
    pal_sel = 1'b0;
    cyc = 0;
    hs_t.delete();
    repeat (100) step();
    chk("R6 back to ntsc first start", hs_t[0], 1 + HN);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule